// File: doc/BRIEF.md
# Instruction Prefetch Pipeline Controller

This block keeps a 16-bit processor's two-stage instruction pipeline filled. It owns the instruction counter, an incoming-word register (stage A), a decode register (stage B) and an immediate-data register. It requests words from memory over a request/acknowledge pair, using the counter as the address. It steers each returned word into the right register and advances the counter by one after every accepted word. When stage B holds a valid instruction, it raises decode-ready. Instruction decoding stays outside the block: the input `needImm` says whether the instruction now in stage B carries an immediate operand, and `instrDone` says that this instruction has finished.

After reset, a jump, a branch, or interrupt or hold processing, the pipeline is empty. A flush loads a new counter value, and the pipeline is then refilled by two back-to-back fetches. The second word of a refill is written into stage A and also into the immediate-data register. If the instruction that reaches stage B turns out to need an operand, the copy in stage A is dropped and one extra fetch refills stage A. The immediate-data register keeps the operand during that fetch.

Top module: `prefetch_pipe`

## Requirements
- R1: On reset the counter holds parameter RESET_ADDR (default 0x0000), both stages are empty, `decodeReady` is low and `fetchReq` is high with `fetchAddr` = RESET_ADDR.
- R2: `fetchAddr` always shows the counter. A request is accepted on a rising clock edge where `fetchReq` and `fetchAck` are both high; `fetchData` is valid in that cycle. While unacknowledged, the address holds. After each accepted word the counter rises by exactly one.
- R3: A word accepted while both stages are empty goes into stage A only; `decodeReady` stays low.
- R4: A word accepted while stage A is valid and stage B is empty moves stage A into stage B, and writes the word into stage A and into the immediate register (`immData`); `decodeReady` then rises with `decodeInstr` equal to the older word.
- R5: While stage B is valid, `needImm` is high, the operand is not yet resolved and stage A is valid, stage A is copied to `immData` and dropped. One further fetch then reloads stage A only, and `immData` is unchanged by it.
- R6: `instrDone` while stage B is valid and its operand (if any) is resolved retires the instruction. A valid stage A moves into stage B, `immData` is unchanged, and exactly one fetch refills stage A. `instrDone` while an operand is still unresolved is ignored.
- R7: `flushValid` loads the counter from `flushAddr` and empties both stages on the same edge, so `decodeReady` is low in the next cycle. A word acknowledged in the flush cycle is discarded and does not advance the counter.
- R8: If a retirement happens while stage A is empty and a word is accepted in the same cycle, that word goes directly into stage B and into `immData`, and stage A stays empty for the next fetch.
- R9: `fetchReq` is low exactly when both stages are valid.
- R10: Counter arithmetic wraps modulo 2^16: a refill starting at 0xFFFF fetches 0xFFFF, then 0x0000, and leaves the counter at 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flushValid | input | 1 | Flush the pipeline and redirect the counter |
| flushAddr | input | 16 | New instruction address for a flush |
| fetchReq | output | 1 | Fetch request to memory |
| fetchAddr | output | 16 | Fetch address (instruction counter) |
| fetchAck | input | 1 | Memory acknowledge; data valid this cycle |
| fetchData | input | 16 | Returned instruction word |
| needImm | input | 1 | Instruction in stage B carries an immediate operand |
| instrDone | input | 1 | Instruction in stage B has completed |
| decodeReady | output | 1 | Stage B holds a valid instruction |
| decodeInstr | output | 16 | Contents of stage B |
| immData | output | 16 | Immediate-data register |

## Verification
Two pairs of functions can land in one cycle. A flush can meet a memory acknowledge, and a retirement can meet the acknowledge of the fetch that refills stage A after an operand was dropped. The bench forces the first with zero wait states, raising a flush at the very edge where a word is acknowledged. It then checks that the pipeline refills from the new address with no trace of the discarded word. It forces the second by adding wait states, watching for `fetchAck` and raising `instrDone` in that same cycle. It then checks that the word sits in `decodeInstr` and `immData` and that exactly one more fetch follows.

// File: rtl/prefetch_pkg.sv
package prefetch_pkg;

  // Strobes from the control FSM to the register datapath
  typedef struct packed {
    logic loadPc;     // counter <- flush target
    logic incPc;      // counter <- counter + 1
    logic aFromBus;   // stage A <- returned word
    logic bFromA;     // stage B <- stage A
    logic bFromBus;   // stage B <- returned word
    logic diFromBus;  // immediate register <- returned word
    logic diFromA;    // immediate register <- stage A
  } pipeCtl_t;

endpackage

// File: rtl/prefetch_ctrl.sv
module prefetch_ctrl
  import prefetch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     flushValid,
  input  logic     fetchAck,
  input  logic     needImm,
  input  logic     instrDone,
  output pipeCtl_t ctl,
  output logic     fetchReq,
  output logic     decodeReady
);

  logic validA, validB, opDone;
  logic validANext, validBNext, opDoneNext;
  logic accept, retire, consume;

  assign fetchReq    = !(validA && validB);
  assign decodeReady = validB;

  assign accept  = fetchReq && fetchAck && !flushValid;
  assign retire  = instrDone && validB && (!needImm || opDone) && !flushValid;
  assign consume = validB && validA && needImm && !opDone && !flushValid;

  always_comb begin
    ctl        = '0;
    validANext = validA;
    validBNext = validB;
    opDoneNext = opDone;
    if (flushValid) begin
      ctl.loadPc = 1'b1;
      validANext = 1'b0;
      validBNext = 1'b0;
      opDoneNext = 1'b0;
    end else if (retire) begin
      opDoneNext = 1'b0;
      if (validA) begin
        ctl.bFromA = 1'b1;
        validANext = 1'b0;
        validBNext = 1'b1;
      end else if (accept) begin
        ctl.bFromBus  = 1'b1;
        ctl.diFromBus = 1'b1;
        ctl.incPc     = 1'b1;
        validBNext    = 1'b1;
      end else begin
        validBNext = 1'b0;
      end
    end else if (accept) begin
      ctl.incPc    = 1'b1;
      ctl.aFromBus = 1'b1;
      validANext   = 1'b1;
      if (validA) begin
        ctl.bFromA    = 1'b1;
        ctl.diFromBus = 1'b1;
        validBNext    = 1'b1;
      end
    end else if (consume) begin
      ctl.diFromA = 1'b1;
      validANext  = 1'b0;
      opDoneNext  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validA <= 1'b0;
      validB <= 1'b0;
      opDone <= 1'b0;
    end else begin
      validA <= validANext;
      validB <= validBNext;
      opDone <= opDoneNext;
    end
  end

  // R7: a flush leaves stage B empty in the following cycle
  p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> !decodeReady);

  // R6: completion while the operand is unresolved does not retire
  p_done_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (validB && needImm && !opDone && instrDone && !flushValid) |=> decodeReady);

  // R4/R8: stage B has at most one source per cycle
  p_b_source_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.bFromA, ctl.bFromBus}));

  // R9: a full pipeline stays full until a retire or flush
  p_full_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchReq && !instrDone && !flushValid && !(needImm && !opDone)) |=> !fetchReq);

endmodule

// File: rtl/prefetch_dpath.sv
module prefetch_dpath
  import prefetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pipeCtl_t          ctl,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic [DATA_W-1:0] fetchData,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regDi
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

  logic [DATA_W-1:0] regA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= RESET_ADDR;
    end else if (ctl.loadPc) begin
      pc <= flushAddr;
    end else if (ctl.incPc) begin
      pc <= pc + PC_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA  <= '0;
      regB  <= '0;
      regDi <= '0;
    end else begin
      if (ctl.aFromBus)       regA <= fetchData;
      if (ctl.bFromA)         regB <= regA;
      else if (ctl.bFromBus)  regB <= fetchData;
      if (ctl.diFromBus)      regDi <= fetchData;
      else if (ctl.diFromA)   regDi <= regA;
    end
  end

  // R2/R10: an increment strobe advances the counter by one, wrapping
  p_pc_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPc && !ctl.loadPc) |=> (pc == $past(pc) + PC_STEP));

endmodule

// File: rtl/prefetch_pipe.sv
module prefetch_pipe
  import prefetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic [DATA_W-1:0] fetchData,
  input  logic              needImm,
  input  logic              instrDone,
  output logic              decodeReady,
  output logic [DATA_W-1:0] decodeInstr,
  output logic [DATA_W-1:0] immData
);

  pipeCtl_t ctl;

  prefetch_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flushValid  (flushValid),
    .fetchAck    (fetchAck),
    .needImm     (needImm),
    .instrDone   (instrDone),
    .ctl         (ctl),
    .fetchReq    (fetchReq),
    .decodeReady (decodeReady)
  );

  prefetch_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .flushAddr (flushAddr),
    .fetchData (fetchData),
    .pc        (fetchAddr),
    .regB      (decodeInstr),
    .regDi     (immData)
  );

  // R2: an unacknowledged request keeps its address
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck && !flushValid) |=> $stable(fetchAddr));

  // R2: an accepted word advances the address by one
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck && !flushValid) |=> (fetchAddr == $past(fetchAddr) + ADDR_W'(1)));

  // R7: a flush redirects the address regardless of any acknowledge
  p_flush_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (fetchAddr == $past(flushAddr)));

  // R5: a word accepted behind a valid stage B, without retirement, leaves the operand alone
  p_imm_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck && decodeReady && !instrDone && !flushValid) |=> $stable(immData));

endmodule

// File: tb/tb_prefetch_pipe.sv
module tb_prefetch_pipe;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushValid = 1'b0;
  logic [15:0] flushAddr = '0;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic [15:0] fetchData;
  logic        needImm = 1'b0;
  logic        instrDone = 1'b0;
  logic        decodeReady;
  logic [15:0] decodeInstr;
  logic [15:0] immData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int waitStates = 0;
  int waitCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  prefetch_pipe dut (
    .clk(clk), .rstN(rstN), .flushValid(flushValid), .flushAddr(flushAddr),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchData(fetchData), .needImm(needImm), .instrDone(instrDone),
    .decodeReady(decodeReady), .decodeInstr(decodeInstr), .immData(immData)
  );

  function automatic logic [15:0] memWord(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  assign fetchData = memWord(fetchAddr);

  // Memory responder: acknowledge after waitStates idle cycles
  always @(negedge clk) begin
    if (!rstN || !fetchReq) begin
      fetchAck = 1'b0;
      waitCnt  = 0;
    end else if (waitCnt >= waitStates) begin
      fetchAck = 1'b1;
      waitCnt  = 0;
    end else begin
      fetchAck = 1'b0;
      waitCnt  = waitCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doFlush(input logic [15:0] addr);
    @(negedge clk);
    flushValid = 1'b1;
    flushAddr  = addr;
    @(negedge clk);
    flushValid = 1'b0;
  endtask

  // Wait (at negedge+1) until the pipeline is full and the counter equals expAddr
  task automatic waitIdle(input string req, input logic [15:0] expAddr);
    bit ok = 0;
    for (int i = 0; i < 100; i++) begin
      #1;
      if (!fetchReq && fetchAddr == expAddr) begin ok = 1; break; end
      @(negedge clk);
    end
    check(req, {31'd0, ok}, 32'd1);
  endtask

  task automatic waitReady(input string req);
    bit ok = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (decodeReady) begin ok = 1; break; end
    end
    check(req, {31'd0, ok}, 32'd1);
  endtask

  task automatic testReset;
    #1;
    check("R1 ready", {31'd0, decodeReady}, 32'd0);
    check("R1 req", {31'd0, fetchReq}, 32'd1);
    check("R1 addr", {16'd0, fetchAddr}, 32'h0000);
  endtask

  task automatic testPlainRefill;
    bit ok = 0;
    waitStates = 2; needImm = 0;
    doFlush(16'h1234);
    #1;
    check("R7 empty after flush", {31'd0, decodeReady}, 32'd0);
    for (int i = 0; i < 50; i++) begin
      if (fetchAddr == 16'h1235) begin ok = 1; break; end
      @(negedge clk); #1;
    end
    check("R3 first word reached", {31'd0, ok}, 32'd1);
    check("R3 not ready after one word", {31'd0, decodeReady}, 32'd0);
    check("R2 addr held during waits", {31'd0, fetchAck}, 32'd0);
    @(negedge clk);
    waitIdle("R9 idle when full", 16'h1236);
    check("R4 decode word", {16'd0, decodeInstr}, {16'd0, memWord(16'h1234)});
    check("R4 second word copied", {16'd0, immData}, {16'd0, memWord(16'h1235)});
    check("R4 ready", {31'd0, decodeReady}, 32'd1);
    // Retire with no operand: A moves to B, one refill
    instrDone = 1;
    @(negedge clk);
    instrDone = 0;
    waitIdle("R6 one refill", 16'h1237);
    check("R6 advanced", {16'd0, decodeInstr}, {16'd0, memWord(16'h1235)});
    check("R6 imm unchanged", {16'd0, immData}, {16'd0, memWord(16'h1235)});
  endtask

  task automatic testImmediate;
    waitStates = 0; needImm = 1;
    doFlush(16'h2000);
    waitIdle("R5 third fetch done", 16'h2003);
    check("R5 decode word", {16'd0, decodeInstr}, {16'd0, memWord(16'h2000)});
    check("R5 operand kept", {16'd0, immData}, {16'd0, memWord(16'h2001)});
    instrDone = 1;
    @(negedge clk);
    instrDone = 0; needImm = 0;
    waitIdle("R6 refill after imm", 16'h2004);
    check("R6 next instr", {16'd0, decodeInstr}, {16'd0, memWord(16'h2002)});
    check("R6 operand unchanged", {16'd0, immData}, {16'd0, memWord(16'h2001)});
  endtask

  task automatic testDoneIgnored;
    waitStates = 0; needImm = 1;
    doFlush(16'h6000);
    waitReady("R6 ready before ignored done");
    instrDone = 1;   // operand not yet resolved in this cycle
    @(negedge clk);
    instrDone = 0;
    waitIdle("R6 ignored done settles", 16'h6003);
    check("R6 done ignored", {16'd0, decodeInstr}, {16'd0, memWord(16'h6000)});
    check("R5 operand", {16'd0, immData}, {16'd0, memWord(16'h6001)});
    needImm = 0;
  endtask

  task automatic testWrap;
    waitStates = 1; needImm = 0;
    doFlush(16'hFFFF);
    waitIdle("R10 wrap idle", 16'h0001);
    check("R10 decode at top", {16'd0, decodeInstr}, {16'd0, memWord(16'hFFFF)});
    check("R10 wrapped word", {16'd0, immData}, {16'd0, memWord(16'h0000)});
  endtask

  task automatic testFlushWithAck;
    waitStates = 0; needImm = 0;
    doFlush(16'h3000);
    #1;
    check("R7 ack present in flush cycle", {31'd0, fetchAck & fetchReq}, 32'd1);
    flushValid = 1; flushAddr = 16'h4000;
    @(negedge clk);
    flushValid = 0;
    waitIdle("R7 refill from new target", 16'h4002);
    check("R7 word discarded", {16'd0, decodeInstr}, {16'd0, memWord(16'h4000)});
    check("R7 imm from new target", {16'd0, immData}, {16'd0, memWord(16'h4001)});
  endtask

  task automatic testRetireWithAck;
    bit ok = 0;
    waitStates = 3; needImm = 1;
    doFlush(16'h5000);
    waitReady("R8 ready");
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (fetchAck && fetchAddr == 16'h5002) begin ok = 1; break; end
    end
    check("R8 third fetch ack seen", {31'd0, ok}, 32'd1);
    instrDone = 1; needImm = 0;
    @(negedge clk);
    instrDone = 0;
    #1;
    check("R8 A empty after direct load", {31'd0, fetchReq}, 32'd1);
    check("R8 ready", {31'd0, decodeReady}, 32'd1);
    waitIdle("R8 one more fetch", 16'h5004);
    check("R8 word into B", {16'd0, decodeInstr}, {16'd0, memWord(16'h5002)});
    check("R8 word into imm", {16'd0, immData}, {16'd0, memWord(16'h5002)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testPlainRefill();
    testImmediate();
    testDoneIgnored();
    testWrap();
    testFlushWithAck();
    testRetireWithAck();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule